// File: doc/BRIEF.md
# Restartable Periodic Interrupt Timer

This block counts single-cycle enable ticks and raises a timeout flag each time a programmed number of ticks has passed. The period comes from a rate-select register that holds a small floating-point style code: a mantissa and a power-of-two exponent. When a period ends, the flag is set and the next period begins on the very next tick. The block does not wait for software to clear the flag, so the rate stays exact even when the flag is serviced late.

Software controls the block with three register operations. It can write the rate code, and any such write restarts the period from zero. It can write a one to the flag to clear it. It can write the interrupt-enable bit. The interrupt request output is the AND of that enable bit and the flag. A rate code of zero parks the timer with no timeouts. A parameter selects how the period counter is built: an up-counter compared against the period, or a down-counter reloaded with it. Both builds behave the same at the ports.

Top module: `pit_timer`

## Requirements
- R1: When the P-th counted tick of a period arrives, `flag_o` reads 1 from the next clock edge on.
- R2: At each timeout the count reloads at once, and the next timeout comes after exactly P more ticks, whether or not the flag has been cleared.
- R3: A write to the rate register restarts the period from zero. A tick in the same cycle as the write is not counted, so the next timeout needs P full ticks at the new rate.
- R4: `irq_o` is 1 exactly when the enable bit `ie_o` is 1 and `flag_o` is 1.
- R5: The rate code holds the mantissa M in bits [3:0] and the exponent E in bits [6:4]. For a non-zero code the period is P = (M+1)·2^E ticks. Only cycles with `tick_en` = 1 advance the count.
- R6: A flag write with `flag_wdata` = 1 clears the flag. A flag write with `flag_wdata` = 0 leaves the flag unchanged.
- R7: If a timeout and a clearing flag write fall in the same cycle, the flag is 1 afterwards.
- R8: While the rate code is 0, no timeouts occur, however many ticks arrive.
- R9: After reset, `rate_o`, `ie_o`, `flag_o` and `irq_o` are all 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick_en | input | 1 | Count-enable tick, one count per high cycle |
| rate_wr | input | 1 | Rate register write strobe |
| rate_wdata | input | 7 | Rate code to write: {exponent[2:0], mantissa[3:0]} |
| flag_wr | input | 1 | Flag register write strobe |
| flag_wdata | input | 1 | 1 clears the flag, 0 has no effect |
| ie_wr | input | 1 | Interrupt-enable write strobe |
| ie_wdata | input | 1 | New interrupt-enable value |
| rate_o | output | 7 | Current rate code |
| ie_o | output | 1 | Current interrupt-enable bit |
| flag_o | output | 1 | Timeout flag |
| irq_o | output | 1 | Interrupt request |

## Verification
The assertions assume two things. The rate register changes only through `rate_wr`, and every strobe and data input is a known 0 or 1 at each rising edge. The checks on count range and reload rest on this, because they compare the counter against the period decoded from the held code. The stimulus drives every input on the falling edge and holds it for one full cycle. Each write strobe lasts exactly one cycle, and ticks are spread by whole cycles, so each edge sees one settled value of every input.

// File: rtl/pit_pkg.sv
package pit_pkg;

   // Selects how the period counter is built.
   typedef enum logic {
      PIT_CNT_UP   = 1'b0,
      PIT_CNT_DOWN = 1'b1
   } pit_cnt_style_e;

endpackage

// File: rtl/pit_period_decode.sv
module pit_period_decode #(
   parameter int MANT_W = 4,
   parameter int EXP_W  = 3,
   localparam int RATE_W = MANT_W + EXP_W,
   localparam int CNT_W  = MANT_W + (1 << EXP_W) - 1
) (
   input  logic [RATE_W-1:0] rate_code,
   output logic [CNT_W-1:0]  period_m1
);

   localparam logic [CNT_W:0] ONE_EXT = {{CNT_W{1'b0}}, 1'b1};

   logic [MANT_W-1:0] mant;
   logic [EXP_W-1:0]  expo;
   logic [CNT_W:0]    base;
   logic [CNT_W:0]    span;

   initial begin : p_param_chk
      assert (MANT_W >= 1 && MANT_W <= 8)
         else $error("pit_period_decode: MANT_W out of range");
      assert (EXP_W >= 1 && EXP_W <= 4)
         else $error("pit_period_decode: EXP_W out of range");
   end

   always_comb begin
      mant      = rate_code[MANT_W-1:0];
      expo      = rate_code[RATE_W-1:MANT_W];
      base      = (CNT_W+1)'(mant) + ONE_EXT;
      span      = base << expo;
      period_m1 = CNT_W'(span - ONE_EXT);
   end

endmodule

// File: rtl/pit_rate_timer.sv
module pit_rate_timer
   import pit_pkg::*;
#(
   parameter int             MANT_W = 4,
   parameter int             EXP_W  = 3,
   parameter pit_cnt_style_e STYLE  = PIT_CNT_UP,
   localparam int RATE_W = MANT_W + EXP_W,
   localparam int CNT_W  = MANT_W + (1 << EXP_W) - 1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              tick_en,
   input  logic              rate_wr,
   input  logic [RATE_W-1:0] rate_wdata,
   output logic [RATE_W-1:0] rate_q,
   output logic              timeout
);

   localparam logic [CNT_W-1:0] CNT_ONE = {{(CNT_W-1){1'b0}}, 1'b1};

   logic [CNT_W-1:0] cnt_q;
   logic [CNT_W-1:0] pm1_cur;
   logic             running;
   logic             adv;

   initial begin : p_param_chk
      assert (CNT_W <= 32) else $error("pit_rate_timer: counter too wide");
   end

   // Rate register: changes only on a write.
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rate_q <= '0;
      end else if (rate_wr) begin
         rate_q <= rate_wdata;
      end
   end

   pit_period_decode #(
      .MANT_W (MANT_W),
      .EXP_W  (EXP_W)
   ) u_dec_cur (
      .rate_code (rate_q),
      .period_m1 (pm1_cur)
   );

   assign running = (rate_q != '0);
   assign adv     = tick_en && running && !rate_wr;

   generate
      if (STYLE == PIT_CNT_UP) begin : g_up
         logic hit;
         assign hit     = adv && (cnt_q == pm1_cur);
         assign timeout = hit;

         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               cnt_q <= '0;
            end else if (rate_wr) begin
               cnt_q <= '0;
            end else if (adv) begin
               cnt_q <= hit ? '0 : cnt_q + CNT_ONE;
            end
         end

         AST_RESTART_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
            rate_wr |=> (cnt_q == '0))
            else $error("restart did not clear count"); // R3
         AST_RELOAD_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
            (timeout && !rate_wr) |=> (cnt_q == '0))
            else $error("count did not reload at timeout"); // R2
      end else begin : g_down
         logic [CNT_W-1:0] pm1_new;
         logic             hit;

         pit_period_decode #(
            .MANT_W (MANT_W),
            .EXP_W  (EXP_W)
         ) u_dec_new (
            .rate_code (rate_wdata),
            .period_m1 (pm1_new)
         );

         assign hit     = adv && (cnt_q == '0);
         assign timeout = hit;

         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               cnt_q <= '0;
            end else if (rate_wr) begin
               cnt_q <= pm1_new;
            end else if (adv) begin
               cnt_q <= hit ? pm1_cur : cnt_q - CNT_ONE;
            end
         end

         AST_RESTART_FULL: assert property (@(posedge clk) disable iff (!rst_n)
            rate_wr |=> (cnt_q == pm1_cur))
            else $error("restart did not load full period"); // R3
         AST_RELOAD_FULL: assert property (@(posedge clk) disable iff (!rst_n)
            (timeout && !rate_wr) |=> (cnt_q == pm1_cur))
            else $error("count did not reload at timeout"); // R2
      end
   endgenerate

   AST_CNT_IN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
      (running && $past(rate_wr)) |-> (cnt_q <= pm1_cur))
      else $error("count beyond period"); // R5
   AST_STOPPED_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
      (rate_q == '0) |-> !timeout)
      else $error("timeout while stopped"); // R8
   AST_IDLE_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
      (!tick_en && !rate_wr) |=> $stable(cnt_q))
      else $error("count moved without tick"); // R5
   AST_RATE_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
      !rate_wr |=> $stable(rate_q))
      else $error("rate changed without write"); // R5

endmodule

// File: rtl/pit_irq_status.sv
module pit_irq_status (
   input  logic clk,
   input  logic rst_n,
   input  logic timeout,
   input  logic flag_wr,
   input  logic flag_wdata,
   input  logic ie_wr,
   input  logic ie_wdata,
   output logic flag_q,
   output logic ie_q,
   output logic irq
);

   logic clr_req;

   assign clr_req = flag_wr && flag_wdata;

   // Set has priority over a clearing write.
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         flag_q <= 1'b0;
      end else if (timeout) begin
         flag_q <= 1'b1;
      end else if (clr_req) begin
         flag_q <= 1'b0;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ie_q <= 1'b0;
      end else if (ie_wr) begin
         ie_q <= ie_wdata;
      end
   end

   assign irq = flag_q && ie_q;

   AST_TIMEOUT_SETS: assert property (@(posedge clk) disable iff (!rst_n)
      timeout |=> flag_q)
      else $error("timeout did not set flag"); // R1
   AST_SET_BEATS_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
      (timeout && clr_req) |=> flag_q)
      else $error("clear won over timeout"); // R7
   AST_CLEAR_ONE: assert property (@(posedge clk) disable iff (!rst_n)
      (clr_req && !timeout) |=> !flag_q)
      else $error("write of one did not clear"); // R6
   AST_WRITE_ZERO_KEEPS: assert property (@(posedge clk) disable iff (!rst_n)
      (flag_wr && !flag_wdata && !timeout) |=> $stable(flag_q))
      else $error("write of zero changed flag"); // R6

endmodule

// File: rtl/pit_timer.sv
module pit_timer
   import pit_pkg::*;
#(
   parameter int             MANT_W = 4,
   parameter int             EXP_W  = 3,
   parameter pit_cnt_style_e STYLE  = PIT_CNT_UP,
   localparam int RATE_W = MANT_W + EXP_W
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              tick_en,
   input  logic              rate_wr,
   input  logic [RATE_W-1:0] rate_wdata,
   input  logic              flag_wr,
   input  logic              flag_wdata,
   input  logic              ie_wr,
   input  logic              ie_wdata,
   output logic [RATE_W-1:0] rate_o,
   output logic              ie_o,
   output logic              flag_o,
   output logic              irq_o
);

   logic timeout;

   pit_rate_timer #(
      .MANT_W (MANT_W),
      .EXP_W  (EXP_W),
      .STYLE  (STYLE)
   ) u_timer (
      .clk        (clk),
      .rst_n      (rst_n),
      .tick_en    (tick_en),
      .rate_wr    (rate_wr),
      .rate_wdata (rate_wdata),
      .rate_q     (rate_o),
      .timeout    (timeout)
   );

   pit_irq_status u_status (
      .clk        (clk),
      .rst_n      (rst_n),
      .timeout    (timeout),
      .flag_wr    (flag_wr),
      .flag_wdata (flag_wdata),
      .ie_wr      (ie_wr),
      .ie_wdata   (ie_wdata),
      .flag_q     (flag_o),
      .ie_q       (ie_o),
      .irq        (irq_o)
   );

   AST_IRQ_NEEDS_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
      (flag_wr && flag_wdata && !timeout) |=> !irq_o)
      else $error("irq survived a flag clear"); // R4

endmodule

// File: tb/pit_timer_tb.sv
module pit_timer_tb;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       tick_en = 1'b0;
   logic       rate_wr = 1'b0;
   logic [6:0] rate_wdata = '0;
   logic       flag_wr = 1'b0;
   logic       flag_wdata = 1'b0;
   logic       ie_wr = 1'b0;
   logic       ie_wdata = 1'b0;
   logic [6:0] rate_o;
   logic       ie_o, flag_o, irq_o;

   int checks = 0;
   int failures = 0;
   bit done = 1'b0;

   always #2 clk = ~clk;

   pit_timer u_dut (
      .clk (clk), .rst_n (rst_n), .tick_en (tick_en),
      .rate_wr (rate_wr), .rate_wdata (rate_wdata),
      .flag_wr (flag_wr), .flag_wdata (flag_wdata),
      .ie_wr (ie_wr), .ie_wdata (ie_wdata),
      .rate_o (rate_o), .ie_o (ie_o), .flag_o (flag_o), .irq_o (irq_o)
   );

   task automatic chk(input string req, input int act, input int exp);
      checks++;
      if (act != exp) begin
         failures++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   task automatic write_rate(input logic [6:0] v);
      @(negedge clk) rate_wr = 1'b1; rate_wdata = v;
      @(negedge clk) rate_wr = 1'b0;
   endtask

   task automatic write_flag(input logic v);
      @(negedge clk) flag_wr = 1'b1; flag_wdata = v;
      @(negedge clk) flag_wr = 1'b0; flag_wdata = 1'b0;
   endtask

   task automatic write_ie(input logic v);
      @(negedge clk) ie_wr = 1'b1; ie_wdata = v;
      @(negedge clk) ie_wr = 1'b0;
   endtask

   // n ticks, each followed by gap idle cycles; ends on a falling edge.
   task automatic ticks(input int n, input int gap);
      for (int i = 0; i < n; i++) begin
         @(negedge clk) tick_en = 1'b1;
         @(negedge clk) tick_en = 1'b0;
         repeat (gap) @(negedge clk);
      end
   endtask

   task automatic period_case(input int m, input int e);
      int p;
      logic [6:0] code;
      p    = (m + 1) << e;
      code = 7'((e << 4) | m);
      write_rate(code);
      write_flag(1'b1);
      ticks(p - 1, 0);
      chk($sformatf("R5 code=%0h before end", code), flag_o, 0);
      ticks(1, 0);
      chk($sformatf("R1 code=%0h at end", code), flag_o, 1);
      write_flag(1'b1);
      chk("R6 clear by one", flag_o, 0);
      ticks(p, 0);
      chk($sformatf("R2 code=%0h next period", code), flag_o, 1);
   endtask

   initial begin : watchdog
      repeat (150000) @(posedge clk);
      if (!done) begin
         failures++;
         $display("FAIL watchdog actual=timeout expected=finish");
         $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
         $finish;
      end
   end

   initial begin : stim
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R9 reset state
      chk("R9 rate", rate_o, 0);
      chk("R9 ie", ie_o, 0);
      chk("R9 flag", flag_o, 0);
      chk("R9 irq", irq_o, 0);

      // R8 parked at code 0
      ticks(40, 0);
      chk("R8 stopped after reset", flag_o, 0);

      // R5/R1/R2 sweep over small exponents, all mantissas
      for (int e = 0; e < 4; e++) begin
         for (int m = 0; m < 16; m++) begin
            if (e != 0 || m != 0) period_case(m, e);
         end
      end
      period_case(15, 7);
      chk("R5 rate readback", rate_o, 7'h7F);

      // R5 sparse ticks: idle cycles do not count
      write_rate(7'h03);
      write_flag(1'b1);
      ticks(3, 2);
      chk("R5 sparse before end", flag_o, 0);
      ticks(1, 2);
      chk("R5 sparse at end", flag_o, 1);

      // R3 restart mid-period
      write_rate(7'h09);
      write_flag(1'b1);
      ticks(7, 0);
      write_rate(7'h09);
      ticks(7, 0);
      chk("R3 restart mid-period", flag_o, 0);
      ticks(3, 0);
      chk("R3 full period after restart", flag_o, 1);

      // R3 write coincides with the final tick
      write_flag(1'b1);
      write_rate(7'h09);
      ticks(9, 0);
      @(negedge clk) tick_en = 1'b1; rate_wr = 1'b1; rate_wdata = 7'h09;
      @(negedge clk) tick_en = 1'b0; rate_wr = 1'b0;
      chk("R3 tick with write not counted", flag_o, 0);
      ticks(9, 0);
      chk("R3 restarted count short", flag_o, 0);
      ticks(1, 0);
      chk("R3 restarted count end", flag_o, 1);

      // R6 write of zero keeps the flag
      write_flag(1'b0);
      chk("R6 write zero", flag_o, 1);

      // R4 interrupt gating
      chk("R4 ie off", irq_o, 0);
      write_ie(1'b1);
      chk("R4 ie readback", ie_o, 1);
      chk("R4 ie on flag set", irq_o, 1);
      write_flag(1'b1);
      chk("R4 flag cleared", irq_o, 0);
      write_ie(1'b0);

      // R8 stop while running
      write_rate(7'h05);
      ticks(3, 0);
      write_rate(7'h00);
      write_flag(1'b1);
      ticks(50, 0);
      chk("R8 stopped while running", flag_o, 0);
      write_rate(7'h05);
      ticks(5, 0);
      chk("R8 resumed short", flag_o, 0);
      ticks(1, 0);
      chk("R8 resumed end", flag_o, 1);

      // R7 timeout and clear in the same cycle, from clear and from set
      write_rate(7'h01);
      write_flag(1'b1);
      ticks(1, 0);
      @(negedge clk) tick_en = 1'b1; flag_wr = 1'b1; flag_wdata = 1'b1;
      @(negedge clk) tick_en = 1'b0; flag_wr = 1'b0; flag_wdata = 1'b0;
      chk("R7 set beats clear", flag_o, 1);
      ticks(1, 0);
      @(negedge clk) tick_en = 1'b1; flag_wr = 1'b1; flag_wdata = 1'b1;
      @(negedge clk) tick_en = 1'b0; flag_wr = 1'b0; flag_wdata = 1'b0;
      chk("R7 set beats clear while set", flag_o, 1);

      done = 1'b1;
      $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

endmodule